// File: doc/BRIEF.md
# H-Bridge Chopper Controller with Dead Time

This block is the digital control for a single winding of a two-winding bipolar stepper driver. One copy is placed per winding. It converts a channel enable and a direction bit into four gate commands: one high-side and one low-side switch for each of the two bridge outputs. It also limits winding current by fixed-off-time chopping.

Chopping works from two inputs. A synchronous over-current flag comes from an external comparator, and a slow chopper clock arrives as a square wave. When the flag trips during drive, the bridge is taken through a dead-time interval with every switch off and then into short brake, with both low sides on. The brake is held for a fixed number of chopper periods. These periods are counted from the first chopper edge after the trip. The bridge then returns to drive through another dead-time interval. A direction change during drive, and every restart, also pass through the dead-time interval.

A thermal-shutdown input turns all switches off. A standby flag reports when this channel and its peer channel are both disabled.

Top module: `hbridge_chopper`

## Requirements
- R1: While `chanEn` is low, all four gate outputs are off from the next clock on, whatever `dirIn` is. This also holds when the bridge is braking.
- R2: In drive with `dirIn` = 1 (forward), `hiOut1` and `loOut2` are on. With `dirIn` = 0 (reverse), `loOut1` and `hiOut2` are on. The bench reads gates as {hiOut1,loOut1,hiOut2,loOut2}: forward 4'b1001, reverse 4'b0110, brake 4'b0101, off 4'b0000.
- R3: `standby` is high in the same cycle exactly when both `chanEn` and `peerEn` are low.
- R4: A `limitTrip` sampled high during drive turns all gates off on the next clock. After DEAD_CYCLES clocks, the bridge enters short brake (4'b0101).
- R5: The chopper clock is synchronised through two flops, and its rising edges are counted. The off timer starts at the first edge after the trip and expires OFF_CLKS edges later. The brake ends one clock after the expiring edge has been counted, and drive resumes after a dead-time interval.
- R6: Every change between drive and brake, and every start of drive, is preceded by at least DEAD_CYCLES clocks with all gates off. Drive never changes directly to brake or to the other diagonal.
- R7: `hiOut1`/`loOut1` are never on together, and neither are `hiOut2`/`loOut2`.
- R8: While `thermalOff` is high, all gates are off from the next clock on, and enable and direction changes have no effect. After it clears, drive resumes after DEAD_CYCLES clocks of all-off.
- R9: `limitTrip` is ignored in the dead-time and brake states. Chopper edges are ignored when no trip is pending.
- R10: A change of `dirIn` during drive gives all-off on the next clock, then the new diagonal after DEAD_CYCLES clocks.
- R11: During reset all gates are off and `standby` follows the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Enable of this channel |
| peerEn | input | 1 | Enable of the other channel (standby only) |
| dirIn | input | 1 | Direction: 1 forward, 0 reverse |
| limitTrip | input | 1 | Synchronous over-current flag from the comparator |
| chopClk | input | 1 | Chopper clock square wave, asynchronous |
| thermalOff | input | 1 | Thermal shutdown request |
| hiOut1 | output | 1 | High-side gate, output 1 |
| loOut1 | output | 1 | Low-side gate, output 1 |
| hiOut2 | output | 1 | High-side gate, output 2 |
| loOut2 | output | 1 | Low-side gate, output 2 |
| standby | output | 1 | Both channels disabled |

## Verification
Some properties are checked on every cycle. The absence of shoot-through on each output leg is one. So is the forced all-off after a disable or a thermal request. The assertions also check that a drive or brake pattern can only change to itself or to all-off, and a counter in the checker ensures every switch-on follows at least DEAD_CYCLES off cycles.

Other behaviour can only be shown by the bench scenarios: the exact clock on which brake ends relative to the third chopper edge, that trips are ignored outside drive, and the diagonal chosen after a direction change or a thermal release.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_DEAD_DRV = 3'd1,
    ST_DRIVE    = 3'd2,
    ST_DEAD_BRK = 3'd3,
    ST_BRAKE    = 3'd4
  } hbcState_e;

  // control -> datapath
  typedef struct packed {
    logic deadLoad;
    logic offArm;
    logic offClear;
  } hbcStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic deadDone;
    logic offDone;
  } hbcStatus_t;

  typedef struct packed {
    logic hi1;
    logic lo1;
    logic hi2;
    logic lo2;
  } gateCmd_t;
endpackage

// File: rtl/hbc_datapath.sv
module hbc_datapath
  import hbc_pkg::*;
#(
  parameter int DEAD_CYCLES = 20,
  parameter int OFF_CLKS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chopClk,
  input  hbcStrobe_t strobe,
  output hbcStatus_t status
);
  localparam int DW = $clog2(DEAD_CYCLES + 1);
  localparam int OW = $clog2(OFF_CLKS + 2);
  localparam logic [DW-1:0] DEAD_START = DW'(DEAD_CYCLES - 1);
  localparam logic [OW-1:0] OFF_LAST   = OW'(OFF_CLKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic chopPrev;
  logic chopEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= chopClk;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], chopClk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) chopPrev <= 1'b0;
    else       chopPrev <= syncQ[SYNC_STAGES-1];
  end

  assign chopEdge = syncQ[SYNC_STAGES-1] & ~chopPrev;

  // dead-time down counter
  logic [DW-1:0] deadCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                deadCnt <= '0;
    else if (strobe.deadLoad) deadCnt <= DEAD_START;
    else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;
  end

  // off timer: counts chopper edges after a trip
  logic          offRunning;
  logic [OW-1:0] offEdges;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offRunning <= 1'b0;
      offEdges   <= '0;
    end else if (strobe.offArm) begin
      offRunning <= 1'b1;
      offEdges   <= '0;
    end else if (strobe.offClear) begin
      offRunning <= 1'b0;
      offEdges   <= '0;
    end else if (offRunning && chopEdge && offEdges != OFF_LAST) begin
      offEdges <= offEdges + 1'b1;
    end
  end

  assign status.deadDone = (deadCnt == '0);
  assign status.offDone  = offRunning && (offEdges == OFF_LAST);
endmodule

// File: rtl/hbc_control.sv
module hbc_control
  import hbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       dirIn,
  input  logic       limitTrip,
  input  logic       thermalOff,
  input  hbcStatus_t status,
  output hbcStrobe_t strobe,
  output gateCmd_t   gates
);
  hbcState_e state, nextState;
  logic curDir;

  always_comb begin
    nextState = state;
    if (!chanEn || thermalOff) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF:      nextState = ST_DEAD_DRV;
        ST_DEAD_DRV: if (status.deadDone) nextState = ST_DRIVE;
        ST_DRIVE: begin
          if (limitTrip)           nextState = ST_DEAD_BRK;
          else if (dirIn != curDir) nextState = ST_DEAD_DRV;
        end
        ST_DEAD_BRK: if (status.deadDone) nextState = ST_BRAKE;
        ST_BRAKE:    if (status.offDone)  nextState = ST_DEAD_DRV;
        default:     nextState = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe.deadLoad = (nextState == ST_DEAD_DRV || nextState == ST_DEAD_BRK)
                      && (nextState != state);
    strobe.offArm   = (state == ST_DRIVE) && (nextState == ST_DEAD_BRK);
    strobe.offClear = !(nextState == ST_DEAD_BRK || nextState == ST_BRAKE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_OFF;
      curDir <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == ST_DRIVE && state != ST_DRIVE) curDir <= dirIn;
    end
  end

  always_comb begin
    gates = '0;
    case (state)
      ST_DRIVE: begin
        if (curDir) begin
          gates.hi1 = 1'b1;
          gates.lo2 = 1'b1;
        end else begin
          gates.lo1 = 1'b1;
          gates.hi2 = 1'b1;
        end
      end
      ST_BRAKE: begin
        gates.lo1 = 1'b1;
        gates.lo2 = 1'b1;
      end
      default: gates = '0;
    endcase
  end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hbc_pkg::*;
#(
  parameter int DEAD_CYCLES = 20,
  parameter int OFF_CLKS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic chanEn,
  input  logic peerEn,
  input  logic dirIn,
  input  logic limitTrip,
  input  logic chopClk,
  input  logic thermalOff,
  output logic hiOut1,
  output logic loOut1,
  output logic hiOut2,
  output logic loOut2,
  output logic standby
);
  hbcStrobe_t strobe;
  hbcStatus_t status;
  gateCmd_t   gates;

  hbc_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .chanEn    (chanEn),
    .dirIn     (dirIn),
    .limitTrip (limitTrip),
    .thermalOff(thermalOff),
    .status    (status),
    .strobe    (strobe),
    .gates     (gates)
  );

  hbc_datapath #(
    .DEAD_CYCLES(DEAD_CYCLES),
    .OFF_CLKS   (OFF_CLKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .chopClk(chopClk),
    .strobe (strobe),
    .status (status)
  );

  assign hiOut1  = gates.hi1;
  assign loOut1  = gates.lo1;
  assign hiOut2  = gates.hi2;
  assign loOut2  = gates.lo2;
  assign standby = ~chanEn & ~peerEn;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
  parameter int DEAD_CYCLES = 20
) (
  input logic clk,
  input logic rstN,
  input logic chanEn,
  input logic thermalOff,
  input logic standby,
  input logic hiOut1,
  input logic loOut1,
  input logic hiOut2,
  input logic loOut2
);
  localparam int CW = $clog2(DEAD_CYCLES + 1);
  logic [3:0] g;
  assign g = {hiOut1, loOut1, hiOut2, loOut2};

  logic [CW-1:0] zeroRun;
  logic lastOff;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroRun <= '0;
      lastOff <= 1'b1;
    end else begin
      lastOff <= (g == 4'b0000);
      if (g != 4'b0000)                   zeroRun <= '0;
      else if (zeroRun != CW'(DEAD_CYCLES)) zeroRun <= zeroRun + 1'b1;
    end
  end

  a_r7_no_shoot_thru: assert property (@(posedge clk) disable iff (!rstN)
    !(hiOut1 && loOut1) && !(hiOut2 && loOut2));

  a_r1_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> g == 4'b0000);

  a_r8_thermal_off: assert property (@(posedge clk) disable iff (!rstN)
    thermalOff |=> g == 4'b0000);

  a_r3_standby_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(standby) |=> g == 4'b0000);

  a_r6_fwd_exit: assert property (@(posedge clk) disable iff (!rstN)
    g == 4'b1001 |=> (g == 4'b1001 || g == 4'b0000));

  a_r6_rev_exit: assert property (@(posedge clk) disable iff (!rstN)
    g == 4'b0110 |=> (g == 4'b0110 || g == 4'b0000));

  a_r6_brake_exit: assert property (@(posedge clk) disable iff (!rstN)
    g == 4'b0101 |=> (g == 4'b0101 || g == 4'b0000));

  a_r6_dead_min: assert property (@(posedge clk) disable iff (!rstN)
    (g != 4'b0000 && lastOff) |-> zeroRun >= CW'(DEAD_CYCLES));
endmodule

bind hbridge_chopper hbc_checker #(.DEAD_CYCLES(DEAD_CYCLES)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .chanEn    (chanEn),
  .thermalOff(thermalOff),
  .standby   (standby),
  .hiOut1    (hiOut1),
  .loOut1    (loOut1),
  .hiOut2    (hiOut2),
  .loOut2    (loOut2)
);

// File: tb/hbridge_chopper_tb_top.sv
module hbridge_chopper_tb_top;
  localparam int DEAD = 20;
  localparam logic [3:0] G_OFF = 4'b0000;
  localparam logic [3:0] G_FWD = 4'b1001;
  localparam logic [3:0] G_REV = 4'b0110;
  localparam logic [3:0] G_BRK = 4'b0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0, peerEn = 1'b0, dirIn = 1'b0;
  logic limitTrip = 1'b0, chopClk = 1'b0, thermalOff = 1'b0;
  logic hiOut1, loOut1, hiOut2, loOut2, standby;
  logic [3:0] gates;
  assign gates = {hiOut1, loOut1, hiOut2, loOut2};

  always #10 clk = ~clk;

  hbridge_chopper #(.DEAD_CYCLES(DEAD), .OFF_CLKS(2), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .peerEn(peerEn), .dirIn(dirIn),
    .limitTrip(limitTrip), .chopClk(chopClk), .thermalOff(thermalOff),
    .hiOut1(hiOut1), .loOut1(loOut1), .hiOut2(hiOut2), .loOut2(loOut2),
    .standby(standby)
  );

  typedef struct {
    string      req;
    logic [3:0] expG;
    bit         chkG;
    bit         expS;
    bit         chkS;
  } item_t;

  item_t sbQ[$];
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // monitor: compares pending expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (it.chkG && gates !== it.expG) begin
        errors++;
        $display("FAIL %s gates actual=%b expected=%b at %0t", it.req, gates, it.expG, $time);
      end
      if (it.chkS && standby !== it.expS) begin
        errors++;
        $display("FAIL %s standby actual=%b expected=%b at %0t", it.req, standby, it.expS, $time);
      end
    end
  end

  task automatic expG(input string req, input logic [3:0] v);
    item_t it;
    it.req = req; it.expG = v; it.chkG = 1'b1; it.expS = 1'b0; it.chkS = 1'b0;
    sbQ.push_back(it);
  endtask

  task automatic expS(input string req, input bit v);
    item_t it;
    it.req = req; it.expG = '0; it.chkG = 1'b0; it.expS = v; it.chkS = 1'b1;
    sbQ.push_back(it);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chopPulse();
    chopClk = 1'b1;
    waitN(3);
    chopClk = 1'b0;
    waitN(3);
  endtask

  // after a change applied at a falling edge: m=1..DEAD off, m=DEAD+1 pattern
  task automatic expectDeadThen(input string req, input logic [3:0] v);
    waitN(1);
    expG(req, G_OFF);
    waitN(DEAD - 1);
    expG(req, G_OFF);
    waitN(1);
    expG(req, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    waitN(3);
    expG("R11 reset gates", G_OFF);
    expS("R11 reset standby", 1'b1);
    waitN(1);
    rstN = 1'b1;
    waitN(2);

    // R3 standby
    peerEn = 1'b1;
    expS("R3 peer enabled", 1'b0);
    waitN(1);
    peerEn = 1'b0;
    expS("R3 both low", 1'b1);
    waitN(1);

    // R1 disabled, direction toggles ignored
    dirIn = 1'b1; waitN(2);
    expG("R1 disabled dir=1", G_OFF);
    dirIn = 0; waitN(2);
    expG("R1 disabled dir=0", G_OFF);

    // enable forward; trip during dead ignored (R9)
    dirIn = 1'b1;
    chanEn = 1'b1;
    expS("R3 channel enabled", 1'b0);
    waitN(5);
    expG("R6 start dead", G_OFF);
    limitTrip = 1'b1;
    waitN(5);
    limitTrip = 1'b0;
    waitN(DEAD - 10);
    expG("R9 trip in dead ignored", G_OFF);
    waitN(1);
    expG("R2 forward", G_FWD);
    waitN(3);
    expG("R2 forward held", G_FWD);

    // R10 direction change
    dirIn = 1'b0;
    expectDeadThen("R10 dir change reverse", G_REV);

    // R4 trip -> dead -> brake; trip held during brake (R9)
    limitTrip = 1'b1;
    expectDeadThen("R4 trip to brake", G_BRK);
    waitN(5);
    expG("R9 trip in brake ignored", G_BRK);

    // R5 off timer: three chopper edges after trip
    chopPulse();
    expG("R5 after first edge", G_BRK);
    chopPulse();
    expG("R5 after second edge", G_BRK);
    limitTrip = 1'b0;
    waitN(2);
    chopClk = 1'b1;
    waitN(3);
    expG("R5 brake until expiry", G_BRK);
    waitN(1);
    chopClk = 1'b0;
    expG("R5 brake ends", G_OFF);
    waitN(DEAD - 1);
    expG("R6 dead before drive", G_OFF);
    waitN(1);
    expG("R6 drive resumes", G_REV);

    // R9 chopper edges without a trip ignored
    chopPulse();
    chopPulse();
    chopPulse();
    expG("R9 chop edges in drive ignored", G_REV);

    // R8 thermal shutdown
    thermalOff = 1'b1;
    waitN(1);
    expG("R8 thermal off", G_OFF);
    dirIn = 1'b1;
    chanEn = 1'b0; waitN(3); chanEn = 1'b1;
    waitN(30);
    expG("R8 held off", G_OFF);
    thermalOff = 1'b0;
    expectDeadThen("R8 restart forward", G_FWD);

    // R1 disable while braking
    limitTrip = 1'b1;
    waitN(DEAD + 3);
    expG("R4 brake again", G_BRK);
    limitTrip = 1'b0;
    chanEn = 1'b0;
    waitN(1);
    expG("R1 disable during brake", G_OFF);
    waitN(1);
    expS("R3 standby again", 1'b1);
    waitN(2);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule